// File: doc/BRIEF.md
# Nibble-serial CRC-16 generator

This block computes a 16-bit check value over a run of 32-bit words, of the kind stored in the header of a configuration ROM area or a bus map. A run opens with a one-cycle `start` pulse, which clears the accumulator and loads a word count. Words then arrive over a valid/ready stream. Each accepted word is folded into the accumulator four bits per clock, taking the most significant nibble first. The update is a shift-and-xor step, not a bit-serial loop or a lookup table.

A run ends in one of two ways: the programmed number of words has been taken, or a word arrives flagged as final. The last nibble of that word then yields a one-cycle `done` pulse, and `crc_out` holds the result until the next `start`. The count is the number of words covered by the check value. For a map header this means the words after the header, not the header itself. Building the header word and fetching the words from memory belong to the surrounding logic.

Top module: `crc16n_gen`

## Requirements
- R1: For each nibble n, with the accumulator a, the block forms s = a[15:12] xor n. The new value is ((a << 4) xor (s << 12) xor (s << 5) xor s), kept to 16 bits. Nibbles of a word are taken in order from bits 31..28 down to bits 3..0.
- R2: A `start` with a nonzero count sets `crc_out` to 0 in the following cycle, with `done` low, so a run never depends on an earlier run.
- R3: With `in_last` held low, the run ends after the word that brings the number of accepted words up to `word_count`, as sampled at `start`.
- R4: A word accepted with `in_last` high ends the run, even if fewer than `word_count` words have been taken.
- R5: `in_ready` is high only while a run waits for its next word. It is low out of reset, after a run ends, and for the 8 cycles after each accepted word. A word offered while `in_ready` is low is not consumed.
- R6: `done` goes high for exactly one cycle, 8 cycles after the clock edge that accepts the final word, with `crc_out` holding the result over all words of the run.
- R7: After `done`, `crc_out` stays unchanged until the next `start`, whatever the stream inputs do.
- R8: A `start` during a run abandons that run: no `done` is raised for it, and the new run's result covers only words accepted after the new `start`.
- R9: A `start` with `word_count` = 0 raises `done` in the next cycle with `crc_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the accumulator and begins a run |
| word_count | input | COUNT_W (10) | Number of words in the run, sampled with `start` |
| in_valid | input | 1 | A word is offered |
| in_data | input | WORD_W (32) | Offered word, big-endian nibble order |
| in_last | input | 1 | Offered word is the final one of the run |
| in_ready | output | 1 | Block takes the offered word at this edge |
| done | output | 1 | One-cycle pulse, result available |
| crc_out | output | 16 | Accumulator and final check value |

## Verification
Three timings matter. `done` and the result are due one cycle after a `start` with a zero count. `in_ready` drops for the 8 cycles after each acceptance. The final `done` comes 8 cycles after the edge that accepts the final word. The bench drives all inputs on falling edges and samples outputs there. It checks `in_ready` at each of the 8 falling edges after an acceptance, and checks that `done` is low at the first seven and high at the eighth. For random runs it waits for the pulse. It then compares `crc_out` with a nibble-by-nibble model and confirms that `done` drops one cycle later.

// File: rtl/crc16n_pkg.sv
package crc16n_pkg;
   localparam int CRC_W = 16;
   localparam int NIB_W = 4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_SHIFT = 2'd2
   } crc16n_state_e;
endpackage

// File: rtl/crc16n_step.sv
module crc16n_step
   import crc16n_pkg::*;
(
   input  logic [CRC_W-1:0] acc_i,
   input  logic [NIB_W-1:0] nib_i,
   output logic [CRC_W-1:0] acc_o
);
   logic [NIB_W-1:0] fold;
   logic [CRC_W-1:0] fold_w;

   always_comb begin
      fold   = acc_i[CRC_W-1 -: NIB_W] ^ nib_i;
      fold_w = {{(CRC_W-NIB_W){1'b0}}, fold};
      acc_o  = (acc_i << NIB_W) ^ (fold_w << 12) ^ (fold_w << 5) ^ fold_w;
   end
endmodule

// File: rtl/crc16n_seq.sv
module crc16n_seq
   import crc16n_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int COUNT_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [COUNT_W-1:0] word_count,
   input  logic               in_valid,
   input  logic               in_last,
   output logic               in_ready,
   output logic               take_word,
   output logic               shift_en,
   output logic               done
);
   localparam int NIBS  = WORD_W / NIB_W;
   localparam int IDX_W = $clog2(NIBS);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NIBS - 1);

   crc16n_state_e      state;
   logic [COUNT_W-1:0] remain;
   logic [IDX_W-1:0]   idx;
   logic               final_q;
   logic               done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         remain  <= '0;
         idx     <= '0;
         final_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            idx     <= '0;
            final_q <= 1'b0;
            remain  <= word_count;
            if (word_count == '0) begin
               state  <= ST_IDLE;
               done_q <= 1'b1;
            end else begin
               state <= ST_WAIT;
            end
         end else begin
            case (state)
               ST_WAIT: begin
                  if (in_valid) begin
                     state   <= ST_SHIFT;
                     idx     <= '0;
                     final_q <= in_last || (remain == COUNT_W'(1));
                     remain  <= remain - COUNT_W'(1);
                  end
               end
               ST_SHIFT: begin
                  idx <= idx + IDX_W'(1);
                  if (idx == IDX_LAST) begin
                     if (final_q) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                     end else begin
                        state <= ST_WAIT;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign in_ready  = (state == ST_WAIT);
   assign take_word = in_ready && in_valid && !start;
   assign shift_en  = (state == ST_SHIFT) && !start;
   assign done      = done_q;
endmodule

// File: rtl/crc16n_gen.sv
module crc16n_gen
   import crc16n_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int COUNT_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [COUNT_W-1:0] word_count,
   input  logic               in_valid,
   input  logic [WORD_W-1:0]  in_data,
   input  logic               in_last,
   output logic               in_ready,
   output logic               done,
   output logic [CRC_W-1:0]   crc_out
);
   generate
      if (WORD_W % NIB_W != 0 || WORD_W < 2 * NIB_W) begin : g_bad_word
         $error("crc16n_gen: WORD_W must be a multiple of 4 and at least 8");
      end
      if (COUNT_W < 1) begin : g_bad_count
         $error("crc16n_gen: COUNT_W must be at least 1");
      end
   endgenerate

   logic              take_word;
   logic              shift_en;
   logic [WORD_W-1:0] hold;
   logic [CRC_W-1:0]  acc;
   logic [CRC_W-1:0]  acc_nxt;

   crc16n_seq #(.WORD_W(WORD_W), .COUNT_W(COUNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .word_count (word_count),
      .in_valid   (in_valid),
      .in_last    (in_last),
      .in_ready   (in_ready),
      .take_word  (take_word),
      .shift_en   (shift_en),
      .done       (done)
   );

   crc16n_step u_step (
      .acc_i (acc),
      .nib_i (hold[WORD_W-1 -: NIB_W]),
      .acc_o (acc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         hold <= '0;
      end else if (start) begin
         acc <= '0;
      end else if (take_word) begin
         hold <= in_data;
      end else if (shift_en) begin
         acc  <= acc_nxt;
         hold <= hold << NIB_W;
      end
   end

   assign crc_out = acc;
endmodule

// File: rtl/crc16n_chk.sv
module crc16n_chk #(
   parameter int COUNT_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [COUNT_W-1:0] word_count,
   input logic               in_valid,
   input logic               in_ready,
   input logic               done,
   input logic [15:0]        crc_out
);
   logic settled_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      settled_q <= 1'b1;
      else if (start)  settled_q <= 1'b0;
      else if (done)   settled_q <= 1'b1;
   end

   assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && word_count != '0) |=> (crc_out == 16'h0 && !done));

   assert_ready_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !start) |=> !in_ready);

   assert_idle_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      settled_q |-> !in_ready);

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (settled_q && !start) |=> $stable(crc_out));

   assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && word_count == '0) |=> (done && crc_out == 16'h0));
endmodule

bind crc16n_gen crc16n_chk #(.COUNT_W(COUNT_W)) u_chk (.*);

// File: tb/tb_crc16n_gen.sv
`timescale 1ns/1ps
module tb_crc16n_gen;
   localparam int WORD_W  = 32;
   localparam int COUNT_W = 10;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [COUNT_W-1:0] word_count = '0;
   logic               in_valid = 1'b0;
   logic [WORD_W-1:0]  in_data = '0;
   logic               in_last = 1'b0;
   logic               in_ready;
   logic               done;
   logic [15:0]        crc_out;

   int total = 0;
   int bad   = 0;
   logic [31:0] words [0:511];
   logic [15:0] got;

   always #5 clk = ~clk;

   crc16n_gen #(.WORD_W(WORD_W), .COUNT_W(COUNT_W)) dut (.*);

   function automatic logic [15:0] ref_crc(input int first, input int n);
      logic [15:0] a = 16'h0;
      logic [3:0]  s;
      for (int w = first; w < first + n; w++) begin
         for (int sh = 28; sh >= 0; sh -= 4) begin
            s = a[15:12] ^ 4'(words[w] >> sh);
            a = (a << 4) ^ (16'(s) << 12) ^ (16'(s) << 5) ^ 16'(s);
         end
      end
      return a;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_start(input int cnt);
      @(negedge clk);
      start = 1'b1;
      word_count = COUNT_W'(cnt);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic send(input logic [31:0] d, input bit last, input int gap);
      repeat (gap) @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      in_last  = last;
      forever begin
         if (in_ready) begin
            @(negedge clk);
            break;
         end
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic wait_done(output logic [15:0] v);
      int n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      v = crc_out;
      check(done == 1'b1, "R6 done seen", 32'(done), 32'd1);
      @(negedge clk);
      check(done == 1'b0, "R6 done one cycle", 32'(done), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // reset state: R5 ready low, R6 no done
      check(in_ready == 1'b0, "R5 reset ready", 32'(in_ready), 0);
      check(done == 1'b0, "R6 reset done", 32'(done), 0);
      check(crc_out == 16'h0, "R2 reset crc", 32'(crc_out), 0);
      rst_n = 1'b1;

      // R9 zero count
      do_start(0);
      check(done == 1'b1, "R9 done next cycle", 32'(done), 1);
      check(crc_out == 16'h0, "R9 zero result", 32'(crc_out), 0);
      @(negedge clk);
      check(done == 1'b0, "R9 done one cycle", 32'(done), 0);

      // directed two-word run with exact timing: R1, R5, R6
      words[0] = 32'h1234_5678;
      words[1] = 32'hF00D_0001;
      do_start(2);
      check(in_ready == 1'b1, "R5 ready in run", 32'(in_ready), 1);
      send(words[0], 1'b0, 0);
      begin
         int lows = 0;
         for (int k = 0; k < 8; k++) begin
            if (!in_ready) lows++;
            @(negedge clk);
         end
         check(lows == 8, "R5 ready low 8 cycles", 32'(lows), 8);
         check(in_ready == 1'b1, "R5 ready back", 32'(in_ready), 1);
      end
      send(words[1], 1'b0, 0);
      begin
         int early = 0;
         for (int k = 1; k < 8; k++) begin
            @(negedge clk);
            if (done) early++;
         end
         check(early == 0, "R6 no early done", 32'(early), 0);
         @(negedge clk);
         check(done == 1'b1, "R6 done at 8th cycle", 32'(done), 1);
         check(crc_out == ref_crc(0, 2), "R1 directed value", 32'(crc_out), 32'(ref_crc(0, 2)));
         @(negedge clk);
         check(done == 1'b0, "R6 pulse ends", 32'(done), 0);
      end

      // R7 hold after done, and R5 words offered while idle are not taken
      got = crc_out;
      in_valid = 1'b1;
      in_data  = 32'hDEAD_BEEF;
      repeat (12) @(negedge clk);
      check(in_ready == 1'b0, "R5 idle ready low", 32'(in_ready), 0);
      check(crc_out == got, "R7 crc held", 32'(crc_out), 32'(got));
      in_valid = 1'b0;
      words[0] = 32'h0000_00A5;
      do_start(1);
      send(words[0], 1'b0, 0);
      wait_done(got);
      check(got == ref_crc(0, 1), "R5 idle word ignored", 32'(got), 32'(ref_crc(0, 1)));

      // random count-terminated runs: R3 and R2
      for (int r = 0; r < 10; r++) begin
         int n = 1 + int'($urandom_range(0, 11));
         for (int i = 0; i < n; i++) words[i] = $urandom;
         if (r == 3) for (int i = 0; i < n; i++) words[i] = 32'hFFFF_FFFF;
         if (r == 4) for (int i = 0; i < n; i++) words[i] = 32'h0;
         do_start(n);
         for (int i = 0; i < n; i++) send(words[i], 1'b0, int'($urandom_range(0, 3)));
         wait_done(got);
         check(got == ref_crc(0, n), "R3 count run", 32'(got), 32'(ref_crc(0, n)));
      end

      // R4 early termination by in_last
      for (int i = 0; i < 3; i++) words[i] = $urandom;
      do_start(20);
      send(words[0], 1'b0, 1);
      send(words[1], 1'b0, 0);
      send(words[2], 1'b1, 2);
      wait_done(got);
      check(got == ref_crc(0, 3), "R4 last flag", 32'(got), 32'(ref_crc(0, 3)));

      // R8 abort mid-word
      for (int i = 0; i < 4; i++) words[i] = $urandom;
      do_start(3);
      send(words[0], 1'b0, 0);
      send(words[1], 1'b1, 0);
      repeat (3) @(negedge clk);
      do_start(2);
      begin
         int spurious = 0;
         for (int k = 0; k < 12; k++) begin
            if (done) spurious++;
            @(negedge clk);
         end
         check(spurious == 0, "R8 no done for aborted run", 32'(spurious), 0);
      end
      send(words[2], 1'b0, 0);
      send(words[3], 1'b0, 1);
      wait_done(got);
      check(got == ref_crc(2, 2), "R8 fresh result", 32'(got), 32'(ref_crc(2, 2)));

      // long map-sized run
      for (int i = 0; i < 300; i++) words[i] = $urandom;
      do_start(300);
      for (int i = 0; i < 300; i++) send(words[i], 1'b0, 0);
      wait_done(got);
      check(got == ref_crc(0, 300), "R3 long run", 32'(got), 32'(ref_crc(0, 300)));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule